// File: doc/BRIEF.md
# Accumulator Machine Processor Core

This block is a small processor built around one 32-bit accumulator and a 32-bit multiplier register. Instructions and data share one word-addressed memory of 16-bit words. Each instruction word carries a 5-bit operation code in bits 15:11 and an 11-bit field in bits 10:0. For most operations that field is a memory address. For the shift operations it is a bit count. The core runs add, subtract, masked-add and multiply-accumulate operations against memory operands. It also has stores that keep or clear the accumulator, branches that test the accumulator sign, shifts, byte input and byte output, and a stop instruction.

Every instruction passes through three phases. In the first, the program counter is placed on the memory address. In the second, the instruction word arrives and the operand address is presented. In the third, the operand arrives and the instruction executes. The memory is synchronous, with read data valid one cycle after the address. A write takes effect on the clock edge of the execute phase. The input and output instructions hold the execute phase until their partner is ready. A preset input can redirect execution to any address at any time, and it also wakes a stopped core.

Top module: `acc_core`

## Requirements
- R1: After reset the core is not halted, the accumulator and multiplier register are zero, no write or output is pending, and the first instruction is fetched from address 0.
- R2: Opcode 0 adds the operand m[n], sign-extended from 16 to 32 bits, to the accumulator. Opcodes 1 and 18 subtract it.
- R3: Opcode 7 adds the sign-extended m[n] into the multiplier register. Opcode 2 adds (sign-extended m[n] AND multiplier register) to the accumulator.
- R4: Opcodes 3 and 20 write the low 16 bits of the accumulator to m[n] and keep the accumulator. Opcodes 10 and 19 write it and then clear the accumulator to zero.
- R5: Opcode 4 branches to n when accumulator bit 31 is 0. Opcode 6 branches to n when bit 31 is 1. In every other case the program counter advances by one, wrapping at 11 bits.
- R6: Opcode 9 shifts the accumulator right arithmetically by n bits, and opcode 11 shifts it left by n bits. Counts of 32 or more yield all sign bits or zero respectively. Opcode 17 loads the accumulator with the sign-extended m[n] shifted right arithmetically by one.
- R7: Opcodes 12 and 21 add the low 32 bits of (sign-extended m[n] times multiplier register) to the accumulator. Opcode 13 subtracts that product.
- R8: Opcode 8 waits until rx_valid is high. In that cycle it raises rx_ready for one cycle and writes {8'h00, rx_data} to m[n].
- R9: Opcode 14 holds tx_valid high with tx_data equal to accumulator bits 7:0 until tx_ready is seen, and sends exactly one byte per instruction.
- R10: Opcode 25 stops the core. halted goes high and stays high, with no memory write, until start_valid is asserted.
- R11: Opcode 23 and the unassigned opcodes 5, 15, 16, 22, 24 and 26 to 31 change neither the accumulator, the multiplier register nor memory, and the program counter advances by one.
- R12: A cycle with start_valid high loads the program counter from start_addr, clears the halt, suppresses that cycle's write, and starts a fetch from start_addr in the next cycle. The accumulator and multiplier register are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Preset the program counter and begin fetching |
| start_addr | input | 11 | Address loaded by start_valid |
| mem_addr | output | 11 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| rx_valid | input | 1 | An input byte is available |
| rx_data | input | 8 | Input byte |
| rx_ready | output | 1 | Input byte taken this cycle |
| tx_valid | output | 1 | Output byte offered |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Receiver takes the offered byte |
| halted | output | 1 | Core is stopped |

## Verification
Several behaviours are checked on every cycle by the assertions:
- an offered output byte stays stable until it is taken;
- an input byte is accepted only when it is valid, and the accepted byte is what gets written;
- a stopped core neither writes nor wakes without a preset;
- a preset redirects the very next fetch.

The arithmetic, the shifts, the sign-tested branches and the keep-or-clear store rules can only be shown by the bench. It runs directed and random programs with stalled handshakes, then compares the final memory image and the output byte stream against an instruction-level model.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int AW   = 11,
  parameter int OPW  = 5,
  parameter int ACW  = 32,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [AW+OPW-1:0] mem_wdata,
  input  logic [AW+OPW-1:0] mem_rdata,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [CW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          halted
);
  localparam int DW = AW + OPW;

  typedef enum logic [1:0] {S_FETCH, S_OPER, S_EXEC, S_HALT} st_t;

  st_t           st;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  logic [ACW-1:0] acc, mreg;
  logic [ACW-1:0] acc_nx, mreg_nx;

  wire [OPW-1:0] op  = ir[DW-1:AW];
  wire [AW-1:0]  fld = ir[AW-1:0];
  wire [ACW-1:0] opd = {{(ACW-DW){mem_rdata[DW-1]}}, mem_rdata};
  wire [ACW-1:0] prod = opd * mreg;

  wire in_exec  = (st == S_EXEC);
  wire is_in    = (op == OPW'(8));
  wire is_out   = (op == OPW'(14));
  wire st_keep  = (op == OPW'(3))  || (op == OPW'(20));
  wire st_clr   = (op == OPW'(10)) || (op == OPW'(19));
  wire is_stop  = (op == OPW'(25));
  wire taken    = ((op == OPW'(4)) && !acc[ACW-1]) || ((op == OPW'(6)) && acc[ACW-1]);
  wire stall    = (is_in && !rx_valid) || (is_out && !tx_ready);
  wire step     = in_exec && !stall && !start_valid;

  assign rx_ready  = in_exec && is_in && rx_valid && !start_valid;
  assign mem_we    = in_exec && !start_valid && (st_keep || st_clr || (is_in && rx_valid));
  assign mem_wdata = is_in ? {{(DW-CW){1'b0}}, rx_data} : acc[DW-1:0];
  assign tx_valid  = in_exec && is_out;
  assign tx_data   = acc[CW-1:0];
  assign halted    = (st == S_HALT);

  always_comb begin
    case (st)
      S_FETCH: mem_addr = pc;
      S_OPER:  mem_addr = mem_rdata[AW-1:0];
      default: mem_addr = (st == S_HALT) ? pc : fld;
    endcase
  end

  always_comb begin
    acc_nx  = acc;
    mreg_nx = mreg;
    case (op)
      OPW'(0):            acc_nx = acc + opd;
      OPW'(1), OPW'(18):  acc_nx = acc - opd;
      OPW'(2):            acc_nx = acc + (opd & mreg);
      OPW'(7):            mreg_nx = mreg + opd;
      OPW'(9):            acc_nx = ACW'($signed(acc) >>> fld);
      OPW'(10), OPW'(19): acc_nx = '0;
      OPW'(11):           acc_nx = acc << fld;
      OPW'(12), OPW'(21): acc_nx = acc + prod;
      OPW'(13):           acc_nx = acc - prod;
      OPW'(17):           acc_nx = ACW'($signed(opd) >>> 1);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_FETCH;
      pc   <= '0;
      ir   <= '0;
      acc  <= '0;
      mreg <= '0;
    end else if (start_valid) begin
      st <= S_FETCH;
      pc <= start_addr;
    end else begin
      case (st)
        S_FETCH: st <= S_OPER;
        S_OPER: begin
          ir <= mem_rdata;
          st <= S_EXEC;
        end
        S_EXEC: if (step) begin
          acc  <= acc_nx;
          mreg <= mreg_nx;
          pc   <= taken ? fld : pc + AW'(1);
          st   <= is_stop ? S_HALT : S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !start_valid |=> tx_valid && $stable(tx_data)); // R9

  AST_RX_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid && !tx_valid); // R8

  AST_RX_WRITES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> mem_we && (mem_wdata == {{(DW-CW){1'b0}}, rx_data})); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !start_valid |=> halted && !mem_we && !tx_valid); // R10

  AST_PRESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |=> !halted && !mem_we && (mem_addr == $past(start_addr))); // R12
endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic        clk = 0, rst_n = 0, start_valid = 0;
  logic [10:0] start_addr = 0, mem_addr;
  logic        mem_we, rx_valid = 0, rx_ready, tx_valid, tx_ready = 0, halted;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic [7:0]  rx_data = 0, tx_data;

  acc_core dut (.clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .halted(halted));

  always #4 clk = ~clk;

  logic [15:0] mem [2048];
  logic [15:0] ref_mem [2048];
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] = mem_wdata;
  end

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] rx_q [16];
  int rx_n = 0, rx_idx = 0, rx_wait = 0;
  bit rx_taken = 0;
  logic [7:0] tx_got [64];
  logic [7:0] tx_exp [64];
  int tg = 0, te = 0, halt_writes = 0;
  logic [31:0] m_acc, m_r;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rx_taken) begin
      rx_idx++; rx_valid = 0; rx_wait = $urandom % 5; rx_taken = 0;
    end else if (!rx_valid && rx_idx < rx_n) begin
      if (rx_wait == 0) begin rx_valid = 1; rx_data = rx_q[rx_idx]; end
      else rx_wait--;
    end
    tx_ready = ($urandom % 3) != 0;
    #1;
    if (rx_valid && rx_ready) rx_taken = 1;
    if (tx_valid && tx_ready && tg < 64) begin tx_got[tg] = tx_data; tg++; end
    if (halted && mem_we) halt_writes++;
  end

  function automatic logic [15:0] ins(input int op, input int n);
    return {op[4:0], n[10:0]};
  endfunction

  task automatic put(input int a, input logic [15:0] v);
    mem[a] = v; ref_mem[a] = v;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) put(i, 16'h0000);
  endtask

  task automatic ref_run(input logic [10:0] start);
    logic [10:0] p = start, np, n;
    logic [15:0] w;
    logic [31:0] opd;
    int op, steps = 0, ri = 0;
    bit run = 1;
    te = 0;
    while (run && steps < 5000) begin
      w = ref_mem[p]; op = int'(w[15:11]); n = w[10:0];
      opd = {{16{ref_mem[n][15]}}, ref_mem[n]};
      np = p + 11'd1;
      case (op)
        0: m_acc = m_acc + opd;
        1, 18: m_acc = m_acc - opd;
        2: m_acc = m_acc + (opd & m_r);
        3, 20: ref_mem[n] = m_acc[15:0];
        4: if (!m_acc[31]) np = n;
        6: if (m_acc[31]) np = n;
        7: m_r = m_r + opd;
        8: begin ref_mem[n] = {8'h00, rx_q[ri]}; ri++; end
        9: m_acc = $signed(m_acc) >>> n;
        10, 19: begin ref_mem[n] = m_acc[15:0]; m_acc = 0; end
        11: m_acc = m_acc << n;
        12, 21: m_acc = m_acc + opd * m_r;
        13: m_acc = m_acc - opd * m_r;
        14: begin tx_exp[te] = m_acc[7:0]; te++; end
        17: m_acc = $signed(opd) >>> 1;
        25: run = 0;
        default: ;
      endcase
      p = np; steps++;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_acc = 0; m_r = 0;
  endtask

  task automatic run(input logic [10:0] start, input bit rst, input bit pulse, input string req);
    int t = 0, bad = 0, first = -1;
    if (rst) do_reset();
    rx_idx = 0; rx_taken = 0; tg = 0; halt_writes = 0;
    ref_run(start);
    if (pulse) begin
      start_addr = start; start_valid = 1;
      @(negedge clk);
      start_valid = 0;
    end
    while (!halted && t < 20000) begin @(negedge clk); t++; end
    chk(halted, req, "halt reached", halted, 1);
    for (int i = 0; i < 2048; i++)
      if (mem[i] !== ref_mem[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1, req, "memory image", 0, 0);
    else chk(0, req, $sformatf("memory word %0d", first), mem[first], ref_mem[first]);
    bad = (tg != te) ? 1 : 0;
    for (int i = 0; i < te && i < tg; i++) if (tx_got[i] !== tx_exp[i]) bad = 1;
    chk(bad == 0, req, "output stream count", tg, te);
    repeat (12) @(negedge clk);
    chk(halted && halt_writes == 0, "R10", "idle after stop, writes seen", halt_writes, 0);
  endtask

  int rops [27] = '{0,1,2,3,7,9,10,11,12,13,17,18,19,20,21,23,5,15,16,22,24,26,27,28,29,30,31};

  task automatic gen_random();
    int op, n;
    clear_mem();
    for (int i = 1024; i < 1064; i++) put(i, 16'($urandom));
    put(1200, 16'hFFFF);
    for (int i = 0; i < 30; i++) begin
      op = rops[$urandom % 27];
      n = (op == 9 || op == 11) ? int'($urandom % 40) : 1024 + int'($urandom % 40);
      put(i, ins(op, n));
    end
    put(30, ins(10, 1100));
    put(31, ins(2, 1200));
    put(32, ins(3, 1101));
    put(33, ins(9, 16));
    put(34, ins(20, 1102));
    put(35, ins(25, 0));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    clear_mem();
    put(0, ins(25, 0));
    do_reset();
    chk(!halted, "R1", "halted after reset", halted, 0);
    chk(!mem_we && !tx_valid && !rx_ready, "R1", "no write or output after reset", mem_we, 0);
    chk(mem_addr == 0, "R1", "first fetch address", mem_addr, 0);

    // R1 R2 R4 R6: directed arithmetic program fetched from address 0 without preset
    clear_mem();
    put(1024, 16'h8000); put(1025, 16'h0003); put(1026, 16'h7FFF);
    put(0, ins(0, 1024)); put(1, ins(3, 1100)); put(2, ins(9, 2047)); put(3, ins(20, 1101));
    put(4, ins(1, 1025)); put(5, ins(18, 1025)); put(6, ins(19, 1102));
    put(7, ins(17, 1024)); put(8, ins(10, 1103)); put(9, ins(0, 1026));
    put(10, ins(11, 17)); put(11, ins(3, 1104)); put(12, ins(9, 16)); put(13, ins(3, 1105));
    put(14, ins(11, 40)); put(15, ins(10, 1106)); put(16, ins(25, 0));
    rx_n = 0;
    run(0, 1, 0, "R2 R4 R6");

    // R3 R7: multiplier register load, masked add, multiply add and subtract
    clear_mem();
    put(1024, 16'h00F3); put(1025, 16'hFFFE); put(1026, 16'h0101);
    put(0, ins(7, 1024)); put(1, ins(7, 1024)); put(2, ins(2, 1025)); put(3, ins(3, 1100));
    put(4, ins(12, 1026)); put(5, ins(20, 1101)); put(6, ins(21, 1025)); put(7, ins(3, 1102));
    put(8, ins(13, 1026)); put(9, ins(13, 1026)); put(10, ins(19, 1103)); put(11, ins(25, 0));
    run(0, 1, 0, "R3 R7");

    // R5 R9: counting loop with sign-tested branches and stalled output
    clear_mem();
    put(1024, 16'd5); put(1025, 16'd1);
    put(0, ins(0, 1024)); put(1, ins(14, 0)); put(2, ins(1, 1025)); put(3, ins(4, 1));
    put(4, ins(6, 6)); put(5, ins(25, 0)); put(6, ins(10, 1030)); put(7, ins(4, 9));
    put(8, ins(25, 0)); put(9, ins(14, 0)); put(10, ins(25, 0));
    run(0, 1, 0, "R5 R9");
    chk(te == 7, "R9", "bytes expected by model", te, 7);

    // R8 R9: input stalls on rx_valid and stores the zero-extended byte
    clear_mem();
    rx_q[0] = 8'hC8; rx_q[1] = 8'h7F; rx_n = 2;
    put(0, ins(8, 1024)); put(1, ins(0, 1024)); put(2, ins(14, 0)); put(3, ins(8, 1025));
    put(4, ins(0, 1025)); put(5, ins(14, 0)); put(6, ins(10, 1026)); put(7, ins(25, 0));
    run(0, 1, 0, "R8 R9");
    chk(rx_idx == 2, "R8", "input bytes consumed", rx_idx, 2);
    rx_n = 0;

    // R11: no-operation and unassigned opcodes leave everything unchanged
    clear_mem();
    put(1024, 16'h1234);
    put(0, ins(0, 1024));
    for (int i = 0; i < 11; i++) put(1 + i, ins(rops[16 + i] == 23 ? 23 : rops[15 + i], 1024));
    put(12, ins(7, 1024)); put(13, ins(23, 1024)); put(14, ins(3, 1100));
    put(15, ins(31, 1100)); put(16, ins(2, 1024)); put(17, ins(10, 1101)); put(18, ins(25, 0));
    run(0, 1, 0, "R11");

    // R12: preset right after reset overrides the fetch from address 0
    clear_mem();
    put(0, ins(25, 0));
    put(1024, 16'h0042);
    put(300, ins(0, 1024)); put(301, ins(10, 1100)); put(302, ins(25, 0));
    put(500, ins(0, 1024)); put(501, ins(0, 1024)); put(502, ins(10, 1101)); put(503, ins(25, 0));
    run(300, 1, 1, "R12");
    // R12: preset wakes a stopped core
    run(500, 0, 1, "R12");

    // R2 R3 R4 R6 R7 R11: random straight-line programs
    for (int k = 0; k < 8; k++) begin
      gen_random();
      run(0, 1, 0, "R2 R3 R4 R6 R7 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule